// File: doc/BRIEF.md
# Serial Configuration Write Port

This block receives configuration writes over a three-wire serial link and keeps them in a small register file. The link has an active-low select, a serial clock and one data line. Every write is a fixed 32-bit frame made of three parts: a synchronising header, a register address and a data word. The frame arrives most significant bit first. When the last bit of a valid frame arrives, the address and data are latched in the serial clock domain. A toggle then carries them into the system clock domain, where they raise a single-cycle write strobe and update the addressed control register.

The port finds each frame by its fixed header. After one frame ends, another may start on the very next serial clock while select stays low, so a host can stream writes without releasing select. A mode input decides whether the stored settings are in force. While the mode is inactive, the register outputs show the power-on defaults and incoming frames are dropped. No read path exists.

Top module: `sercfg_port`

## Requirements
- R1: A frame is 32 bits sampled on rising `sclk`, first bit most significant. Bits 31..20 are the header 0x001, which is eleven zeros, the first bit sent being zero, followed by a one. Bits 19..16 are the address, bit 19 sent first. Bits 15..0 are the data word, bit 15 sent first.
- R2: Bits are taken only while `sel_n` is low. Raising `sel_n` before bit 32 throws away the partial frame, and no write follows.
- R3: A frame whose 12 header bits differ from 0x001 commits nothing. While `sel_n` stays low the port hunts for the header in the bits that follow, so a valid frame after stray bits is still taken.
- R4: With `sel_n` held low, a new frame may begin on the 33rd `sclk`, and every frame in such a run is committed.
- R5: Each committed frame gives exactly one `wr_stb` pulse, one `clk` cycle wide, with the frame's address on `wr_addr` and its data on `wr_data`.
- R6: Eight registers sit at addresses 0x1, 0x2, 0x3, 0xA, 0xB, 0xD, 0xE and 0xF. `regs_q` slot k (bits 16k+15..16k) is the k-th of these in ascending address order. Reset values: 0x1=0xB2FF, 0x2=0x007F, 0x3=0x807F, 0xA=0x007F, 0xB=0x807F, 0xD=0x0000, 0xE=0x007F, 0xF=0x007F.
- R7: A write to any other address still pulses `wr_stb` and changes no register.
- R8: In the register at 0x1, bits 15, 13 and 7..0 always read 1 and bit 14 always reads 0, whatever data is written.
- R9: While `ext_mode` is low, `regs_q` shows the reset values, and a frame that arrives gives no strobe and no write. Values stored earlier come back when `ext_mode` returns high.
- R10: After reset, every register holds its reset value and `wr_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | High puts stored settings in force and allows writes |
| sel_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data input |
| wr_stb | output | 1 | One-cycle strobe for each committed frame |
| wr_addr | output | 4 | Address of the last committed frame |
| wr_data | output | 16 | Data of the last committed frame |
| regs_q | output | 128 | Effective register values, eight 16-bit slots |

## Verification
The bench builds the port with its default parameters: a 12-bit header, a 4-bit address, 16-bit data, two synchroniser stages and the eight-register address map. Together these reach header hunting after stray bits, frames aborted at every bit position and runs of back-to-back frames. Because every one of the sixteen addresses can be hit, writes to unimplemented slots are covered as well as the forced bits of the register at 0x1. With a serial clock eight times slower than `clk`, the toggle has settled long before the next frame could overwrite the held word.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_BODY = 1'b1
  } frm_state_e;
endpackage

// File: rtl/sercfg_rstsync.sv
module sercfg_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb chain_d = {chain_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
  import sercfg_pkg::*;
#(
  parameter int          HDR_W   = 12,
  parameter logic [11:0] HDR_PAT = 12'h001,
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 16
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sdata,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              tgl
);
  localparam int BODY_W  = ADDR_W + DATA_W;
  localparam int FRAME_W = HDR_W + BODY_W;
  localparam int MAXC    = (BODY_W > HDR_W) ? BODY_W : HDR_W;
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(BODY_W - 1);

  // frame assembly state, cleared whenever select is released
  logic              frm_rst_n;
  frm_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR_W-1:0]  win_q, win_d;
  logic [BODY_W-1:0] body_q, body_d;
  logic              commit;

  // committed frame, kept across select toggles
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              tgl_q, tgl_d;

  assign frm_rst_n = rst_n & ~sel_n;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    win_d  = {win_q[HDR_W-2:0], sdata};
    body_d = body_q;
    commit = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (cnt_q < HDR_LAST) cnt_d = cnt_q + 1'b1;
        if ((cnt_q >= HDR_LAST) && (win_d == HDR_PAT)) begin
          st_d  = ST_BODY;
          cnt_d = '0;
        end
      end
      ST_BODY: begin
        body_d = {body_q[BODY_W-2:0], sdata};
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == BODY_LAST) begin
          commit = 1'b1;
          st_d   = ST_HUNT;
          cnt_d  = '0;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      win_q  <= '0;
      body_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      win_q  <= win_d;
      body_q <= body_d;
    end
  end

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    tgl_d  = tgl_q;
    if (commit) begin
      addr_d = body_d[BODY_W-1:DATA_W];
      data_d = body_d[DATA_W-1:0];
      tgl_d  = ~tgl_q;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      tgl_q  <= tgl_d;
    end
  end

  assign hold_addr = addr_q;
  assign hold_data = data_q;
  assign tgl       = tgl_q;

  // bits seen since select fell, for the checks below
  logic [7:0] seen_q;
  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n)         seen_q <= '0;
    else if (seen_q != 8'hFF) seen_q <= seen_q + 1'b1;
  end

  // R2
  sel_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    sel_n |=> $stable(tgl_q));

  // R1
  frame_len_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (tgl_q != $past(tgl_q)) |-> ($past(seen_q) >= 8'(FRAME_W - 1)));
endmodule

// File: rtl/sercfg_xfer.sv
module sercfg_xfer #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              ext_mode,
  input  logic              tgl_in,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   seen_q, seen_d;
  logic                   stb_q, stb_d;
  logic [ADDR_W-1:0]      addr_q, addr_d;
  logic [DATA_W-1:0]      data_q, data_d;
  logic                   arrived;

  always_comb begin
    sync_d  = {sync_q[SYNC_STAGES-2:0], tgl_in};
    seen_d  = sync_q[SYNC_STAGES-1];
    arrived = sync_q[SYNC_STAGES-1] ^ seen_q;
    stb_d   = arrived & ext_mode;
    addr_d  = addr_q;
    data_d  = data_q;
    if (stb_d) begin
      addr_d = hold_addr;
      data_d = hold_data;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sync_q <= sync_d;
      seen_q <= seen_d;
      stb_q  <= stb_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |=> !wr_stb);

  // R9
  stb_mode_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |-> $past(ext_mode));
endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter logic [(1<<ADDR_W)-1:0]        IMPL_MASK = '0,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] REG_DFLT  = '0,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] FIX_MASK  = '0,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] FIX_VAL   = '0
) (
  input  logic                       clk,
  input  logic                       srst_n,
  input  logic                       ext_mode,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_q
);
  localparam int NADDR = 1 << ADDR_W;

  function automatic int slot_addr(input int slot);
    int seen;
    seen = 0;
    for (int a = 0; a < NADDR; a++) begin
      if (IMPL_MASK[a]) begin
        if (seen == slot) return a;
        seen++;
      end
    end
    return 0;
  endfunction

  logic [NUM_REGS*DATA_W-1:0] stored_flat;

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
    localparam int SA = slot_addr(s);
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(SA);
    localparam logic [DATA_W-1:0] DF = REG_DFLT[SA*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] FM = FIX_MASK[SA*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] FV = FIX_VAL[SA*DATA_W +: DATA_W];

    logic              hit;
    logic [DATA_W-1:0] val_q, val_d;

    always_comb begin
      hit   = wr_en && (wr_addr == SADDR);
      val_d = val_q;
      if (hit) val_d = (wr_data & ~FM) | (FV & FM);
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) val_q <= DF;
      else         val_q <= val_d;
    end

    assign stored_flat[s*DATA_W +: DATA_W] = val_q;
    assign regs_q[s*DATA_W +: DATA_W]      = ext_mode ? val_q : DF;

    // R8
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (val_q & FM) == (FV & FM));
  end

  // R7
  rsvd_write_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !IMPL_MASK[wr_addr]) |=> $stable(stored_flat));
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port #(
  parameter int          HDR_W       = 12,
  parameter logic [11:0] HDR_PAT     = 12'h001,
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 16,
  parameter int          NUM_REGS    = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 16'hEC0E,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] REG_DFLT = {
    16'h007F, 16'h007F, 16'h0000, 16'h0000,
    16'h807F, 16'h007F, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h807F, 16'h007F, 16'hB2FF, 16'h0000},
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] FIX_MASK = 256'hE0FF << 16,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] FIX_VAL  = 256'hA0FF << 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_mode,
  input  logic                       sel_n,
  input  logic                       sclk,
  input  logic                       sdata,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_q
);
  logic              srst_n;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              tgl;

  sercfg_rstsync i_rstsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sercfg_shifter #(
    .HDR_W   (HDR_W),
    .HDR_PAT (HDR_PAT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) i_shifter (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .sdata     (sdata),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .tgl       (tgl)
  );

  sercfg_xfer #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_xfer (
    .clk       (clk),
    .srst_n    (srst_n),
    .ext_mode  (ext_mode),
    .tgl_in    (tgl),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  sercfg_regfile #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .IMPL_MASK (IMPL_MASK),
    .REG_DFLT  (REG_DFLT),
    .FIX_MASK  (FIX_MASK),
    .FIX_VAL   (FIX_VAL)
  ) i_regfile (
    .clk      (clk),
    .srst_n   (srst_n),
    .ext_mode (ext_mode),
    .wr_en    (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .regs_q   (regs_q)
  );
endmodule

// File: tb/test_sercfg_port.sv
`timescale 1ns/1ps
module test_sercfg_port;
  localparam int NREG  = 8;
  localparam int SHALF = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_mode = 1'b1;
  logic          sel_n = 1'b1;
  logic          sclk = 1'b0;
  logic          sdata = 1'b0;
  logic          wr_stb;
  logic [3:0]    wr_addr;
  logic [15:0]   wr_data;
  logic [127:0]  regs_q;

  int n_chk = 0;
  int n_bad = 0;
  int stb_cnt = 0;
  int exp_stb = 0;
  int pulse_err = 0;
  logic        prev_stb = 1'b0;
  logic [3:0]  last_a = '0;
  logic [15:0] last_d = '0;
  logic [3:0]  exp_a = '0;
  logic [15:0] exp_d = '0;
  logic [15:0] mdl [16];

  always #2.5 clk = ~clk;

  sercfg_port i_sercfg_port (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sel_n(sel_n),
    .sclk(sclk), .sdata(sdata), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_q(regs_q));

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_cnt++;
        last_a = wr_addr;
        last_d = wr_data;
        if (prev_stb) pulse_err++;
      end
      prev_stb = wr_stb;
    end
  end

  function automatic logic impl(input logic [3:0] a);
    return a inside {4'h1, 4'h2, 4'h3, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};
  endfunction

  function automatic logic [15:0] dflt(input logic [3:0] a);
    case (a)
      4'h1: return 16'hB2FF;
      4'h2, 4'hA, 4'hE, 4'hF: return 16'h007F;
      4'h3, 4'hB: return 16'h807F;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] forced(input logic [3:0] a, input logic [15:0] d);
    if (a == 4'h1) return (d & ~16'hE0FF) | 16'hA0FF;
    return d;
  endfunction

  function automatic logic [3:0] slot_to_addr(input int s);
    int k = 0;
    for (int a = 0; a < 16; a++) begin
      if (impl(4'(a))) begin
        if (k == s) return 4'(a);
        k++;
      end
    end
    return 4'h0;
  endfunction

  function automatic logic [31:0] mkframe(input logic [3:0] a, input logic [15:0] d);
    return {12'h001, a, d};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int s = 0; s < NREG; s++) begin
      logic [3:0]  a = slot_to_addr(s);
      logic [15:0] e = ext_mode ? mdl[a] : dflt(a);
      check(req, $sformatf("slot %0d addr %0h", s, a), 32'(regs_q[s*16 +: 16]), 32'(e));
    end
  endtask

  task automatic check_stb(input string req);
    check(req, "strobe count", 32'(stb_cnt), 32'(exp_stb));
    check("R5", "strobe width errors", 32'(pulse_err), 32'd0);
  endtask

  task automatic bit_out(input logic b);
    sdata = b;
    #(SHALF) sclk = 1'b1;
    #(SHALF) sclk = 1'b0;
  endtask

  task automatic shift(input logic [31:0] f, input int nbits);
    for (int i = 0; i < nbits; i++) bit_out(f[31-i]);
  endtask

  task automatic open_sel();
    sel_n = 1'b0;
    #(SHALF);
  endtask

  task automatic close_sel();
    #(SHALF) sel_n = 1'b1;
    #(SHALF);
  endtask

  // model a complete valid frame
  task automatic expect_write(input logic [3:0] a, input logic [15:0] d);
    if (ext_mode) begin
      exp_stb++;
      exp_a = a;
      exp_d = d;
      if (impl(a)) mdl[a] = forced(a, d);
    end
  endtask

  task automatic write1(input logic [3:0] a, input logic [15:0] d);
    open_sel();
    shift(mkframe(a, d), 32);
    close_sel();
    expect_write(a, d);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int a = 0; a < 16; a++) mdl[a] = dflt(4'(a));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset values, strobe idle
    check("R10", "wr_stb after reset", 32'(wr_stb), 32'd0);
    check_regs("R10");
    check("R6", "slot0 reset", 32'(regs_q[15:0]), 32'h0000B2FF);

    // R1: single write, checked on the strobe fields
    write1(4'h2, 16'h1234);
    settle();
    check_regs("R1");
    check("R5", "wr_addr", 32'(last_a), 32'(exp_a));
    check("R5", "wr_data", 32'(last_d), 32'(exp_d));
    check_stb("R5");

    // R8: forced bits of register 0x1
    write1(4'h1, 16'h0000);
    settle();
    check("R8", "cfg after zero write", 32'(regs_q[15:0]), 32'h0000A0FF);
    write1(4'h1, 16'hFFFF);
    settle();
    check("R8", "cfg after ones write", 32'(regs_q[15:0]), 32'h0000BFFF);

    // R7: unimplemented address
    write1(4'h5, 16'hDEAD);
    settle();
    check_regs("R7");
    check_stb("R7");
    check("R7", "wr_addr", 32'(last_a), 32'h5);

    // R4: three frames back to back with select held low
    open_sel();
    shift(mkframe(4'hA, 16'h0A0A), 32); expect_write(4'hA, 16'h0A0A);
    shift(mkframe(4'hB, 16'h0B0B), 32); expect_write(4'hB, 16'h0B0B);
    shift(mkframe(4'hF, 16'h0F0F), 32); expect_write(4'hF, 16'h0F0F);
    close_sel();
    settle();
    check_regs("R4");
    check_stb("R4");

    // R2: abort after 31 bits
    open_sel();
    shift(mkframe(4'h3, 16'h5555), 31);
    close_sel();
    settle();
    check_regs("R2");
    check_stb("R2");

    // R3: all-zero header, then hunting after stray ones
    open_sel();
    shift({12'h000, 4'h3, 16'h7777}, 32);
    close_sel();
    settle();
    check_regs("R3");
    check_stb("R3");
    open_sel();
    shift(32'hFFFF_FFFF, 5);
    shift(mkframe(4'hE, 16'h4321), 32);
    close_sel();
    expect_write(4'hE, 16'h4321);
    settle();
    check_regs("R3");
    check_stb("R3");

    // R9: mode low shows defaults and drops frames
    ext_mode = 1'b0;
    repeat (2) @(negedge clk);
    check_regs("R9");
    write1(4'h2, 16'hBEEF);
    settle();
    check_stb("R9");
    ext_mode = 1'b1;
    repeat (2) @(negedge clk);
    check_regs("R9");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind = int'($urandom % 8);
      logic [3:0]  a = 4'($urandom);
      logic [15:0] d = 16'($urandom);
      case (kind)
        4: begin
          int n = 2 + int'($urandom % 2);
          open_sel();
          for (int k = 0; k < n; k++) begin
            logic [3:0]  ak = 4'($urandom);
            logic [15:0] dk = 16'($urandom);
            shift(mkframe(ak, dk), 32);
            expect_write(ak, dk);
          end
          close_sel();
        end
        5: begin
          open_sel();
          shift(mkframe(a, d), 1 + int'($urandom % 31));
          close_sel();
        end
        6: begin
          logic [31:0] f = mkframe(a, d);
          f[20 + int'($urandom % 12)] ^= 1'b1;
          open_sel();
          shift(f, 32);
          close_sel();
        end
        7: begin
          ext_mode = ~ext_mode;
          repeat (2) @(negedge clk);
          write1(a, d);
        end
        default: write1(a, d);
      endcase
      settle();
      check_regs(kind == 5 ? "R2" : (kind == 6 ? "R3" : (kind == 4 ? "R4" : "R6")));
      check_stb(kind == 7 ? "R9" : "R5");
    end

    ext_mode = 1'b1;
    repeat (2) @(negedge clk);
    check_regs("R6");
    finish_run();
  end
endmodule